// File: doc/BRIEF.md
# Prioritised Exception Entry Controller

This block decides which exception a processor core takes, and carries out the change of processor state for that exception in one clock edge. Six request lines come in: reset, data abort, fast interrupt, normal interrupt, undefined instruction and software trap. The controller holds the current status word. Fast and normal interrupts are masked by two bits of that word. Among the unmasked requests, the one with the highest priority wins.

On the edge where an exception is taken, several things happen together. The old status word is saved into the bank that belongs to the target mode. The caller's return address is written into that bank's link slot. The status word gets its new mode, the state bit is cleared and the disable bits are set. A one-cycle program-counter load is issued with the vector address.

A return command undoes an entry. It copies the saved status word of the current mode back into the status word and issues a program-counter load with the saved link value. A plain status-write port lets software-visible code change flags, masks and mode.

All pins are plain control levels sampled on the rising clock edge. No path carries a data stream, so there is no valid/ready handshake and no back-pressure: a request that is not taken on an edge has no lasting effect, and the caller must keep it asserted until it is taken.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, `status_o` reads 0x000000D3 (supervisor mode 10011, both disable bits set, state bit clear, flags zero), and `pc_load_o` is 0.
- R2: At most one exception is taken per edge. The fixed priority is reset, then data abort, then fast interrupt, then normal interrupt, then undefined instruction, then software trap.
- R3: A normal interrupt request is ignored while status bit 7 (I) is 1. A fast interrupt request is ignored while status bit 6 (F) is 1. A masked request lets a lower-priority request be taken.
- R4: When an undefined-instruction request and a software-trap request arrive on the same edge, the undefined instruction is taken.
- R5: On entry, the status word as it was before the edge is stored in the target mode's bank. A later return from that mode restores it exactly, including bits 31:28 (N, Z, C, V).
- R6: On entry, bits 4:0 become the target mode: reset 10011, data abort 10111, fast interrupt 10001, normal interrupt 10010, undefined 11011, software trap 10011. Bit 5 (T) is cleared and bit 7 (I) is set. Bit 6 (F) is set for reset and fast interrupt and is otherwise unchanged. Bits 31:28 are kept.
- R7: The entry edge raises `pc_load_o` and `entry_o` for one cycle. `pc_addr_o` is VEC_BASE plus the offset: reset 0x00, undefined 0x04, software trap 0x08, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C. `kind_o` codes the exception as 1 reset, 2 abort, 3 fast, 4 normal, 5 undefined, 6 trap.
- R8: On entry, `ret_addr_i` is stored as the target bank's link value. A return raises `pc_load_o` with `entry_o` = 0 and `pc_addr_o` equal to the link value of the current mode.
- R9: A return command is ignored (no load, status unchanged) in the following cases: in user mode 10000, in any mode without a bank, and on an edge where an exception is taken.
- R10: `stat_wr_en_i` loads bits 31:28 and 7:0 from `stat_wr_data_i`; all other status bits read 0. The write is dropped on an edge that takes an exception or performs a return.
- R11: Banks are kept per mode, so nested entries into different modes return in reverse order to each earlier state and address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_reset_i | input | 1 | Reset exception request |
| req_abort_i | input | 1 | Data abort request |
| req_fiq_i | input | 1 | Fast interrupt request |
| req_irq_i | input | 1 | Normal interrupt request |
| req_undef_i | input | 1 | Undefined instruction request |
| req_swi_i | input | 1 | Software trap request |
| ret_addr_i | input | AW | Return address stored on entry |
| eret_i | input | 1 | Exception return command |
| stat_wr_en_i | input | 1 | Status word write enable |
| stat_wr_data_i | input | 32 | Status word write value |
| status_o | output | 32 | Current status word |
| pc_load_o | output | 1 | Program counter load pulse |
| pc_addr_o | output | AW | Program counter load value |
| entry_o | output | 1 | Load is an exception entry (1) or a return (0) |
| kind_o | output | 3 | Code of the exception taken |

## Verification
The assertions check, on every cycle, that the arbiter grants at most one request, that a granted fast or normal interrupt was not masked, that a software trap is never granted next to an undefined request, and that each bank slot holds what was written into it. They also check that every entry load is word aligned and leaves I set, T clear and the flags unchanged, and that a return in user mode does nothing. Only the bench scenarios can show the concrete vector and mode for each exception, the exact status word after a return, and the order in which nested entries unwind across banks.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int NUM_EXC  = 6;
  localparam int NUM_BANK = 5;
  localparam int BANK_IW  = 3;

  // request index, highest priority first
  localparam int IX_RESET = 0;
  localparam int IX_ABORT = 1;
  localparam int IX_FIQ   = 2;
  localparam int IX_IRQ   = 3;
  localparam int IX_UNDEF = 4;
  localparam int IX_SWI   = 5;

  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;

  localparam int BIT_I = 7;
  localparam int BIT_F = 6;
  localparam int BIT_T = 5;

  localparam logic [31:0] PSR_IMPL  = 32'hF00000FF;
  localparam logic [31:0] PSR_RESET = 32'h000000D3;

  typedef enum logic [2:0] {
    EK_NONE  = 3'd0,
    EK_RESET = 3'd1,
    EK_ABORT = 3'd2,
    EK_FIQ   = 3'd3,
    EK_IRQ   = 3'd4,
    EK_UNDEF = 3'd5,
    EK_SWI   = 3'd6
  } exc_kind_e;

  typedef struct packed {
    logic               ok;
    logic [BANK_IW-1:0] idx;
  } bank_sel_t;

  function automatic bank_sel_t mode_bank(input logic [4:0] m);
    bank_sel_t s;
    s.ok  = 1'b1;
    s.idx = '0;
    case (m)
      MODE_FIQ: s.idx = 3'd0;
      MODE_IRQ: s.idx = 3'd1;
      MODE_SVC: s.idx = 3'd2;
      MODE_ABT: s.idx = 3'd3;
      MODE_UND: s.idx = 3'd4;
      default:  s.ok  = 1'b0;
    endcase
    return s;
  endfunction

  function automatic logic [4:0] kind_mode(input exc_kind_e k);
    case (k)
      EK_RESET: return MODE_SVC;
      EK_ABORT: return MODE_ABT;
      EK_FIQ:   return MODE_FIQ;
      EK_IRQ:   return MODE_IRQ;
      EK_UNDEF: return MODE_UND;
      EK_SWI:   return MODE_SVC;
      default:  return MODE_USR;
    endcase
  endfunction

  function automatic logic [7:0] kind_offset(input exc_kind_e k);
    case (k)
      EK_UNDEF: return 8'h04;
      EK_SWI:   return 8'h08;
      EK_ABORT: return 8'h10;
      EK_IRQ:   return 8'h18;
      EK_FIQ:   return 8'h1C;
      default:  return 8'h00;
    endcase
  endfunction

  function automatic logic kind_sets_f(input exc_kind_e k);
    return (k == EK_RESET) || (k == EK_FIQ);
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int NREQ = NUM_EXC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req_i,
  input  logic            irq_mask_i,
  input  logic            fiq_mask_i,
  output logic [NREQ-1:0] grant_o,
  output exc_kind_e       kind_o
);

  logic [NREQ-1:0] eff;

  always_comb begin
    eff          = req_i;
    eff[IX_FIQ]  = req_i[IX_FIQ] & ~fiq_mask_i;
    eff[IX_IRQ]  = req_i[IX_IRQ] & ~irq_mask_i;
  end

  for (genvar g = 0; g < NREQ; g++) begin : g_ladder
    if (g == 0) begin : g_top
      assign grant_o[g] = eff[g];
    end else begin : g_rest
      assign grant_o[g] = eff[g] & ~(|eff[g-1:0]);
    end
  end

  always_comb begin
    kind_o = EK_NONE;
    for (int i = 0; i < NREQ; i++) begin
      if (grant_o[i]) kind_o = exc_kind_e'(3'(i + 1));
    end
  end

  a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  a_r2_irq_below: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o[IX_IRQ] |-> !req_i[IX_RESET] && !req_i[IX_ABORT] &&
                        !(req_i[IX_FIQ] && !fiq_mask_i));

  a_r3_fiq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o[IX_FIQ] |-> !fiq_mask_i);

  a_r3_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o[IX_IRQ] |-> !irq_mask_i);

  a_r4_undef_first: assert property (@(posedge clk) disable iff (!rst_n)
    req_i[IX_UNDEF] |-> !grant_o[IX_SWI]);

endmodule

// File: rtl/exc_target.sv
module exc_target
  import exc_pkg::*;
#(
  parameter int          AW       = 32,
  parameter logic [AW-1:0] VEC_BASE = '0
) (
  input  exc_kind_e     kind_i,
  output logic [4:0]    mode_o,
  output logic          set_f_o,
  output logic [AW-1:0] vec_o
);

  always_comb begin
    mode_o  = kind_mode(kind_i);
    set_f_o = kind_sets_f(kind_i);
    vec_o   = VEC_BASE + AW'(kind_offset(kind_i));
  end

endmodule

// File: rtl/exc_bank.sv
module exc_bank
  import exc_pkg::*;
#(
  parameter int NB = NUM_BANK,
  parameter int IW = BANK_IW,
  parameter int DW = 32,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_psr_i,
  input  logic [AW-1:0] wr_lr_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [DW-1:0] rd_psr_o,
  output logic [AW-1:0] rd_lr_o
);

  logic [DW-1:0] psr_q [NB];
  logic [AW-1:0] lr_q  [NB];

  for (genvar b = 0; b < NB; b++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        psr_q[b] <= '0;
        lr_q[b]  <= '0;
      end else if (wr_en_i && (wr_idx_i == IW'(b))) begin
        psr_q[b] <= wr_psr_i;
        lr_q[b]  <= wr_lr_i;
      end
    end

    a_r5_slot_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && (wr_idx_i == IW'(b))) |=>
        (psr_q[b] == $past(wr_psr_i)) && (lr_q[b] == $past(wr_lr_i)));
  end

  always_comb begin
    rd_psr_o = '0;
    rd_lr_o  = '0;
    for (int b = 0; b < NB; b++) begin
      if (rd_idx_i == IW'(b)) begin
        rd_psr_o = psr_q[b];
        rd_lr_o  = lr_q[b];
      end
    end
  end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int            AW       = 32,
  parameter logic [AW-1:0] VEC_BASE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_reset_i,
  input  logic          req_abort_i,
  input  logic          req_fiq_i,
  input  logic          req_irq_i,
  input  logic          req_undef_i,
  input  logic          req_swi_i,
  input  logic [AW-1:0] ret_addr_i,
  input  logic          eret_i,
  input  logic          stat_wr_en_i,
  input  logic [31:0]   stat_wr_data_i,
  output logic [31:0]   status_o,
  output logic          pc_load_o,
  output logic [AW-1:0] pc_addr_o,
  output logic          entry_o,
  output logic [2:0]    kind_o
);

  logic [31:0]        status_q;
  logic [NUM_EXC-1:0] req_vec;
  logic [NUM_EXC-1:0] grant;
  exc_kind_e          kind;
  logic               take;
  logic [4:0]         tgt_mode;
  logic               tgt_set_f;
  logic [AW-1:0]      tgt_vec;
  bank_sel_t          cur_bank;
  bank_sel_t          tgt_bank;
  logic [31:0]        saved_psr;
  logic [AW-1:0]      saved_lr;
  logic               do_ret;
  logic [31:0]        status_d;

  always_comb begin
    req_vec           = '0;
    req_vec[IX_RESET] = req_reset_i;
    req_vec[IX_ABORT] = req_abort_i;
    req_vec[IX_FIQ]   = req_fiq_i;
    req_vec[IX_IRQ]   = req_irq_i;
    req_vec[IX_UNDEF] = req_undef_i;
    req_vec[IX_SWI]   = req_swi_i;
  end

  exc_arbiter #(.NREQ(NUM_EXC)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_vec),
    .irq_mask_i (status_q[BIT_I]),
    .fiq_mask_i (status_q[BIT_F]),
    .grant_o    (grant),
    .kind_o     (kind)
  );

  exc_target #(.AW(AW), .VEC_BASE(VEC_BASE)) u_tgt (
    .kind_i  (kind),
    .mode_o  (tgt_mode),
    .set_f_o (tgt_set_f),
    .vec_o   (tgt_vec)
  );

  assign take     = |grant;
  assign cur_bank = mode_bank(status_q[4:0]);
  assign tgt_bank = mode_bank(tgt_mode);
  assign do_ret   = !take && eret_i && cur_bank.ok;

  exc_bank #(.NB(NUM_BANK), .IW(BANK_IW), .DW(32), .AW(AW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (take),
    .wr_idx_i (tgt_bank.idx),
    .wr_psr_i (status_q),
    .wr_lr_i  (ret_addr_i),
    .rd_idx_i (cur_bank.idx),
    .rd_psr_o (saved_psr),
    .rd_lr_o  (saved_lr)
  );

  always_comb begin
    status_d = status_q;
    if (take) begin
      status_d           = status_q & PSR_IMPL;
      status_d[4:0]      = tgt_mode;
      status_d[BIT_T]    = 1'b0;
      status_d[BIT_I]    = 1'b1;
      status_d[BIT_F]    = status_q[BIT_F] | tgt_set_f;
    end else if (do_ret) begin
      status_d = saved_psr & PSR_IMPL;
    end else if (stat_wr_en_i) begin
      status_d = stat_wr_data_i & PSR_IMPL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q  <= PSR_RESET;
      pc_load_o <= 1'b0;
      pc_addr_o <= '0;
      entry_o   <= 1'b0;
      kind_o    <= EK_NONE;
    end else begin
      status_q  <= status_d;
      pc_load_o <= take | do_ret;
      entry_o   <= take;
      kind_o    <= kind;
      if (take)        pc_addr_o <= tgt_vec;
      else if (do_ret) pc_addr_o <= saved_lr;
    end
  end

  assign status_o = status_q;

  a_r7_vec_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    entry_o |-> pc_load_o && (pc_addr_o[1:0] == 2'b00));

  a_r6_entry_bits: assert property (@(posedge clk) disable iff (!rst_n)
    entry_o |-> status_o[BIT_I] && !status_o[BIT_T] &&
                (status_o[31:28] == $past(status_o[31:28])));

  a_r9_user_return: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_i && (status_o[4:0] == MODE_USR) && !stat_wr_en_i &&
     !req_reset_i && !req_abort_i && !req_fiq_i && !req_irq_i &&
     !req_undef_i && !req_swi_i)
      |=> !pc_load_o && (status_o == $past(status_o)));

  a_r10_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[27:8] == '0);

endmodule

// File: tb/exc_entry_ctrl_tb_top.sv
module exc_entry_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_reset, req_abort, req_fiq, req_irq, req_undef, req_swi;
  logic [31:0] ret_addr;
  logic        eret;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] status;
  logic        pc_load;
  logic [31:0] pc_addr;
  logic        entry;
  logic [2:0]  kind;

  int n_checks = 0;
  int n_bad    = 0;

  always #4 clk = ~clk;

  exc_entry_ctrl #(.AW(32), .VEC_BASE(32'h0)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_reset_i    (req_reset),
    .req_abort_i    (req_abort),
    .req_fiq_i      (req_fiq),
    .req_irq_i      (req_irq),
    .req_undef_i    (req_undef),
    .req_swi_i      (req_swi),
    .ret_addr_i     (ret_addr),
    .eret_i         (eret),
    .stat_wr_en_i   (wr_en),
    .stat_wr_data_i (wr_data),
    .status_o       (status),
    .pc_load_o      (pc_load),
    .pc_addr_o      (pc_addr),
    .entry_o        (entry),
    .kind_o         (kind)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got=0x%08h exp=0x%08h", req, what, got, exp);
    end
  endtask

  task automatic idle();
    req_reset = 0; req_abort = 0; req_fiq = 0; req_irq = 0;
    req_undef = 0; req_swi = 0; eret = 0; wr_en = 0;
    wr_data = '0; ret_addr = '0;
  endtask

  // drive at a falling edge, let one rising edge pass, sample at the next falling edge
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic set_status(input logic [31:0] v);
    wr_en = 1; wr_data = v;
    step();
  endtask

  task automatic fire(input logic [5:0] reqs, input logic [31:0] ra);
    {req_swi, req_undef, req_irq, req_fiq, req_abort, req_reset} = reqs;
    ret_addr = ra;
    step();
  endtask

  task automatic do_return();
    eret = 1;
    step();
  endtask

  task automatic t_reset_state();
    chk("R1", "status after reset", status, 32'h000000D3);
    chk("R1", "no load after reset", {31'b0, pc_load}, 32'h0);
  endtask

  task automatic t_status_write();
    set_status(32'hFFFFFFFF);
    chk("R10", "write masks bits", status, 32'hF00000FF);
    do_return(); // mode 11111 has no bank
    chk("R9", "return in bankless mode no load", {31'b0, pc_load}, 32'h0);
    chk("R9", "return in bankless mode status", status, 32'hF00000FF);
  endtask

  task automatic t_irq_round_trip();
    set_status(32'hA0000010);
    fire(6'b001000, 32'h0000_4440);
    chk("R7", "irq load", {30'b0, pc_load, entry}, 32'h3);
    chk("R7", "irq vector", pc_addr, 32'h18);
    chk("R7", "irq kind", {29'b0, kind}, 32'd4);
    chk("R6", "irq status", status, 32'hA0000092);
    step();
    chk("R7", "load is one cycle", {31'b0, pc_load}, 32'h0);
    do_return();
    chk("R8", "return load", {30'b0, pc_load, entry}, 32'h2);
    chk("R8", "return address", pc_addr, 32'h0000_4440);
    chk("R5", "restored status", status, 32'hA0000010);
  endtask

  task automatic t_priority_ladder();
    set_status(32'h50000010);
    fire(6'b111111, 32'h100);
    chk("R2", "reset wins vector", pc_addr, 32'h0);
    chk("R6", "reset status", status, 32'h500000D3);
    set_status(32'h00000010);
    fire(6'b111110, 32'h104);
    chk("R2", "abort wins vector", pc_addr, 32'h10);
    chk("R6", "abort status", status, 32'h00000097);
    set_status(32'h00000010);
    fire(6'b011100, 32'h108);
    chk("R2", "fiq wins vector", pc_addr, 32'h1C);
    chk("R6", "fiq status", status, 32'h000000D1);
    set_status(32'h00000010);
    fire(6'b111000, 32'h10C);
    chk("R2", "irq beats undef/swi", pc_addr, 32'h18);
  endtask

  task automatic t_masking();
    set_status(32'h00000090);
    fire(6'b101000, 32'h200);
    chk("R3", "masked irq falls to swi", pc_addr, 32'h08);
    chk("R6", "swi status", status, 32'h00000093);
    set_status(32'h00000050);
    fire(6'b000100, 32'h204);
    chk("R3", "masked fiq no load", {31'b0, pc_load}, 32'h0);
    chk("R3", "masked fiq status", status, 32'h00000050);
    set_status(32'h00000050);
    fire(6'b001100, 32'h208);
    chk("R3", "fiq masked irq taken", pc_addr, 32'h18);
    chk("R6", "F kept on irq entry", status, 32'h000000D2);
  endtask

  task automatic t_undef_swi();
    set_status(32'h00000030);
    fire(6'b110000, 32'h300);
    chk("R4", "undef over swi vector", pc_addr, 32'h04);
    chk("R6", "undef clears T", status, 32'h0000009B);
  endtask

  task automatic t_return_ignored();
    set_status(32'h00000010);
    do_return();
    chk("R9", "user return no load", {31'b0, pc_load}, 32'h0);
    chk("R9", "user return status", status, 32'h00000010);
    set_status(32'h00000092);
    eret = 1;
    fire(6'b010000, 32'h400);
    chk("R9", "entry beats return", {30'b0, pc_load, entry}, 32'h3);
    chk("R9", "entry vector", pc_addr, 32'h04);
    chk("R9", "entry status", status, 32'h0000009B);
    set_status(32'h00000010);
    wr_en = 1; wr_data = 32'h000000FF;
    fire(6'b000010, 32'h404);
    chk("R10", "write dropped on entry", status, 32'h00000097);
  endtask

  task automatic t_nested();
    set_status(32'h50000010);
    fire(6'b001000, 32'h1000);
    chk("R11", "first entry", status, 32'h50000092);
    fire(6'b000010, 32'h2000);
    chk("R11", "second entry", status, 32'h50000097);
    do_return();
    chk("R11", "unwind one addr", pc_addr, 32'h2000);
    chk("R11", "unwind one status", status, 32'h50000092);
    do_return();
    chk("R11", "unwind two addr", pc_addr, 32'h1000);
    chk("R11", "unwind two status", status, 32'h50000010);
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    t_reset_state();
    t_status_write();
    t_irq_round_trip();
    t_priority_ladder();
    t_masking();
    t_undef_swi();
    t_return_ignored();
    t_nested();
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_bad++;
    $display("FAIL watchdog: got=timeout exp=completion");
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule